// File: doc/BRIEF.md
# Bus-Triggered Unsigned Multiplier

This block puts an unsigned 8-by-8 multiplier on an 8-bit host bus at two neighbouring register slots. A one-bit address select picks the slot: 0 is the low slot and 1 is the high slot. The host writes the multiplicand into the low slot. It then writes the multiplier into the high slot, and that write launches the multiplication. The 16-bit product is built by a shift-add engine over eight clocks. A busy flag is raised for that time. When the engine finishes, the product lands in a result register. The host reads the result register back one byte at a time through the same two slots.

Reading the high slot hands out the upper product byte and then wipes the result register to zero. The register is therefore consumed by a low-then-high read pair. The stored multiplicand stays in place between launches, so a host that keeps one factor fixed only has to rewrite the high slot.

The engine is a two-state machine. `ST_IDLE` waits for a launch. `ST_CALC` runs one shift-add step per clock with a step counter. It has four transitions:

- *launch*: `ST_IDLE` to `ST_CALC` on a high-slot write.
- *step*: `ST_CALC` to `ST_CALC` while steps remain.
- *relaunch*: `ST_CALC` to `ST_CALC` on a high-slot write during a calculation, which resets the step counter.
- *finish*: `ST_CALC` to `ST_IDLE` after the eighth step, which commits the product.

Top module: `bus_mult8`

## Requirements
- R1: After reset the busy flag is 0, the result register reads 0 from both slots, and the stored multiplicand is 0.
- R2: A write with `sel_hi`=0 stores `wdata` as the multiplicand.
- R3: A write with `sel_hi`=1 takes `wdata` as the multiplier and launches a calculation. `busy` is 1 from the clock edge that samples the write for exactly 8 cycles, and 0 after the eighth following edge.
- R4: Once `busy` has fallen, a read with `sel_hi`=0 returns bits 7..0 of the unsigned product, combinationally in the cycle `rd_en` is high.
- R5: A read with `sel_hi`=1 returns bits 15..8 of the product. At the clock edge ending that read, the result register becomes 0, so later reads of either slot return 0.
- R6: A read with `sel_hi`=0 leaves the result register unchanged.
- R7: While `busy` is 1, reads return the result register from before the launch.
- R8: A high-slot write while `busy` is 1 abandons the running calculation. It restarts with the current multiplicand and the new multiplier, `busy` stays 1 for 8 cycles after that write, and the committed product uses the new operands.
- R9: A low-slot write while `busy` is 1 does not change the running calculation, but the new value is used by the next launch.
- R10: The multiplicand persists across launches, so repeated high-slot writes multiply the same stored multiplicand.
- R11: `rdata` is 0 in any cycle where `rd_en` is 0.
- R12: The product is exact at the operand extremes (0×n, 1×255, 255×255 = 0xFE01).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_hi | input | 1 | Slot select: 0 low slot, 1 high slot |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| busy | output | 1 | Calculation in progress |

## Verification
The assertions take for granted that the host never raises `wr_en` and `rd_en` together. They also assume that each access lasts a single cycle with `sel_hi` steady for that cycle. Without these, a read-clear and a launch could meet on one edge. The stimulus follows this by moving every bus signal only on the falling clock edge and performing each access as one strobed cycle followed by an idle cycle. High-slot reads during a calculation are left out of the stimulus except where the rule in R5 is the point of the test.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Engine states of the shift-add multiplier
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } bm_state_e;

    // Decoded bus access for one cycle
    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
    } bm_access_t;

endpackage

// File: rtl/bm_decode.sv
module bm_decode
    import bm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_hi,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    output bm_access_t   acc_o,
    output logic [W-1:0] mcand_q
);

    // Slot decode
    always_comb begin
        acc_o.wr_lo = wr_en & ~sel_hi;
        acc_o.wr_hi = wr_en &  sel_hi;
        acc_o.rd_lo = rd_en & ~sel_hi;
        acc_o.rd_hi = rd_en &  sel_hi;
    end

    // Stored multiplicand (low slot)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
        end else if (acc_o.wr_lo) begin
            mcand_q <= wdata;
        end
    end

    // R2: a low-slot write lands in the multiplicand register
    assert_lo_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_hi) |=> (mcand_q == $past(wdata)));

    // R10: without a low-slot write the multiplicand holds
    assert_mcand_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !sel_hi) |=> $stable(mcand_q));

endmodule

// File: rtl/bm_engine.sv
module bm_engine
    import bm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    output logic            busy,
    output logic            commit,
    output logic [2*W-1:0]  product
);

    localparam int PW = 2 * W;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    bm_state_e      state_q, state_d;
    logic [CW-1:0]  step_q;
    logic [PW-1:0]  acc_q;
    logic [PW-1:0]  shifted_q;
    logic [W-1:0]   mplr_q;
    logic [PW-1:0]  acc_nx;
    logic           last_step;

    assign last_step = (step_q == LAST);
    assign acc_nx    = acc_q + (mplr_q[0] ? shifted_q : '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: launch, step, relaunch, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_CALC;          // launch
            end
            ST_CALC: begin
                if (start)          state_d = ST_CALC; // relaunch
                else if (last_step) state_d = ST_IDLE; // finish
                else                state_d = ST_CALC; // step
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (state_q == ST_CALC);
        commit  = (state_q == ST_CALC) && last_step && !start;
        product = acc_nx;
    end

    // Datapath: one shift-add step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= '0;
            acc_q     <= '0;
            shifted_q <= '0;
            mplr_q    <= '0;
        end else if (start) begin
            step_q    <= '0;
            acc_q     <= '0;
            shifted_q <= {{W{1'b0}}, opa};
            mplr_q    <= opb;
        end else if (state_q == ST_CALC) begin
            step_q    <= step_q + 1'b1;
            acc_q     <= acc_nx;
            shifted_q <= shifted_q << 1;
            mplr_q    <= mplr_q >> 1;
        end
    end

    // R8: a launch always leaves the engine busy at step zero
    assert_launch_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && step_q == '0));

    // R3: completion drops busy on the following cycle
    assert_finish_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    // R3: an idle engine stays idle without a launch
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/bm_result.sv
module bm_result
    import bm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bm_access_t      acc_i,
    input  logic            commit,
    input  logic [2*W-1:0]  product,
    output logic [W-1:0]    rdata
);

    logic [2*W-1:0] res_q;

    // Result register: commit wins over a read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (commit) begin
            res_q <= product;
        end else if (acc_i.rd_hi) begin
            res_q <= '0;
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (acc_i.rd_lo) rdata = res_q[W-1:0];
        if (acc_i.rd_hi) rdata = res_q[2*W-1:W];
    end

    // R5: a high-slot read clears the result
    assert_hi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.rd_hi && !commit) |=> (res_q == '0));

    // R6/R7: without commit or high read the result holds
    assert_res_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !acc_i.rd_hi) |=> $stable(res_q));

endmodule

// File: rtl/bus_mult8.sv
module bus_mult8
    import bm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_hi,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         busy
);

    localparam int PW = 2 * W;

    bm_access_t    acc;
    logic [W-1:0]  mcand;
    logic          commit;
    logic [PW-1:0] product;

    bm_decode #(.W(W)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_hi  (sel_hi),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .acc_o   (acc),
        .mcand_q (mcand)
    );

    bm_engine #(.W(W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (acc.wr_hi),
        .opa     (mcand),
        .opb     (wdata),
        .busy    (busy),
        .commit  (commit),
        .product (product)
    );

    bm_result #(.W(W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc),
        .commit  (commit),
        .product (product),
        .rdata   (rdata)
    );

    // R3: busy only rises on the cycle after a high-slot write
    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && sel_hi));

    // R8: a high-slot write keeps or makes the block busy
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_hi) |=> busy);

    // R11: read data is zero outside read cycles
    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

endmodule

// File: tb/tb_bus_mult8.sv
module tb_bus_mult8;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_hi = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_mult8 #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic hi, input logic [W-1:0] d);
        @(negedge clk);
        sel_hi = hi; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic hi, output logic [W-1:0] d);
        @(negedge clk);
        sel_hi = hi; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Launch a product and check the busy window (R3)
    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
        bus_wr(1'b0, a);
        bus_wr(1'b1, b);
        check("R3 busy after launch", busy, 1);
        idle(7);
        check("R3 busy through step 8", busy, 1);
        idle(1);
        check("R3 busy cleared", busy, 0);
    endtask

    // Read both bytes and compare with the expected product (R4, R5)
    task automatic read_pair(input string tag, input int exp);
        logic [W-1:0] lo, hi;
        bus_rd(1'b0, lo);
        bus_rd(1'b1, hi);
        check({tag, " R4 low byte"}, lo, exp & 8'hFF);
        check({tag, " R5 high byte"}, hi, (exp >> 8) & 8'hFF);
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        check("R1 busy at reset", busy, 0);
        check("R11 rdata quiet", rdata, 0);
        bus_rd(1'b0, d); check("R1 low byte at reset", d, 0);
        bus_rd(1'b1, d); check("R1 high byte at reset", d, 0);
        // multiplicand is zero after reset: high write alone gives zero
        bus_wr(1'b1, 8'd77);
        idle(8);
        read_pair("R1 multiplicand zero", 0);
    endtask

    task automatic t_basic();
        logic [W-1:0] d;
        launch(8'd12, 8'd34);   // R2 operand stored
        bus_rd(1'b0, d); check("R4 low byte", d, (12*34) & 8'hFF);
        bus_rd(1'b0, d); check("R6 low read keeps result", d, (12*34) & 8'hFF);
        bus_rd(1'b1, d); check("R5 high byte", d, (12*34) >> 8);
        bus_rd(1'b0, d); check("R5 cleared low", d, 0);
        bus_rd(1'b1, d); check("R5 cleared high", d, 0);
        check("R11 rdata quiet after reads", rdata, 0);
    endtask

    task automatic t_corners();
        launch(8'd0, 8'd200);   read_pair("R12 zero", 0);
        launch(8'd1, 8'd255);   read_pair("R12 one", 255);
        launch(8'd255, 8'd255); read_pair("R12 max", 16'hFE01);
        launch(8'hA5, 8'h5A);   read_pair("R4 pattern", 8'hA5 * 8'h5A);
    endtask

    task automatic t_read_busy();
        logic [W-1:0] d;
        launch(8'd200, 8'd3);          // result 600 = 0x0258 kept
        bus_wr(1'b1, 8'd5);            // launch 200*5 while keeping old result
        bus_rd(1'b0, d); check("R7 low during busy", d, 8'h58);
        check("R7 still busy", busy, 1);
        idle(6);
        check("R3 idle after relaunch window", busy, 0);
        read_pair("R7 new product", 1000);
    endtask

    task automatic t_restart();
        bus_wr(1'b0, 8'd17);
        bus_wr(1'b1, 8'd9);
        idle(3);
        bus_wr(1'b1, 8'd100);          // relaunch
        idle(7);
        check("R8 busy extended", busy, 1);
        idle(1);
        check("R8 busy ends", busy, 0);
        read_pair("R8 latest operands", 1700);
    endtask

    task automatic t_lo_during_busy();
        bus_wr(1'b0, 8'd7);
        bus_wr(1'b1, 8'd11);
        bus_wr(1'b0, 8'd250);          // during busy
        idle(7);
        check("R9 done", busy, 0);
        read_pair("R9 running calc unchanged", 77);
        bus_wr(1'b1, 8'd11);
        idle(8);
        read_pair("R9 next launch new value", 2750);
        bus_wr(1'b1, 8'd2);            // R10 same multiplicand again
        idle(8);
        read_pair("R10 multiplicand kept", 500);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_corners();
        t_read_busy();
        t_restart();
        t_lo_during_busy();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule